// File: doc/BRIEF.md
# Interrupt Request Hub

The hub collects fourteen peripheral event lines into one level interrupt for a processor. Each event line is edge-detected. A rising edge latches a sticky request flag. Software reads the flags, writes ones to acknowledge them, and chooses which sources may interrupt through an enable register. A single master bit gates the whole output.

Three registers sit in a 16-byte window, reached through a simple bus port. The port carries a request strobe, a write strobe, an access size and a byte offset. Byte, halfword and word accesses are supported. The write data and the read data use the low lanes of the 32-bit buses. One word access at offset 0x0 covers the enable register and the flag register together. Offsets that hold no register read as zero, and writes to them change nothing.

Top module: `irq_hub`

## Requirements
- R1: After a synchronous active-low reset, the enable register, the flag register, the master bit and `irq_out` are all zero.
- R2: A 0-to-1 transition on an `evt_in` bit sets the matching flag. A line held high does not set the flag again after the flag is cleared.
- R3: If a rising event and an acknowledge of the same flag fall in the same cycle, the flag ends up set.
- R4: A halfword write at offset 0x2, or a byte write at offset 0x2 or 0x3, clears each flag whose written bit is one. Offset 0x2 covers bits 7:0 and offset 0x3 covers bits 15:8. Flags whose written bit is zero keep their value, and no flag clears without a write.
- R5: A word write at offset 0x0 loads the enable register from data bits 15:0. The same write clears every flag whose bit in data bits 31:16 is one.
- R6: Reads return data in the low lanes. A word read at offset 0x0 returns the flags in bits 31:16 and the enable register in bits 15:0. A halfword read returns the enable register at offset 0x0 and the flags at offset 0x2. A byte read at offset 0x0, 0x1, 0x2 or 0x3 returns, in that order, enable bits 7:0, enable bits 15:8, flag bits 7:0 and flag bits 15:8.
- R7: A halfword write at offset 0x0 replaces the whole enable register. A byte write at offset 0x0 replaces only enable bits 7:0, and a byte write at offset 0x1 replaces only enable bits 15:8.
- R8: Any write to offset 0x8 (byte, halfword or word) keeps only data bit 0 as the master bit. A read at offset 0x8 returns the master bit in bit 0 and zero in all other bits.
- R9: `irq_out` is a register. After each clock edge it equals master AND (OR of enable AND flags), taken from the register values held before that edge.
- R10: Enable and flag bits 15:14 always read zero. Reads at unmapped offsets (0x4, 0x6, 0xA, 0xC and others), and reads with size code 3, return zero. Writes of these kinds change no register. Size code 0 is byte, 1 is halfword and 2 is word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word |
| bus_addr | input | 4 | Byte offset inside the window |
| bus_wdata | input | 32 | Write data, low-lane aligned |
| bus_rdata | output | 32 | Read data, valid while a read is strobed, zero otherwise |
| evt_in | input | 14 | Peripheral event lines |
| irq_out | output | 1 | Registered level interrupt |

## Verification
The bench lands a rising event in the same cycle as an all-ones acknowledge. A design that gives clear the priority would lose that event. It holds an event line high across an acknowledge; a level-sensitive design would set the flag again at once. It uses word writes whose two halves carry different patterns. A design that ignored the upper half, or took enable data from the wrong lane, would leave stale flags or a wrong enable value. Writes of all-ones to unmapped offsets and to the master bit, followed by read-back, catch decode aliasing and stray stored bits. Every step also compares `irq_out` with the value from the previous cycle, which catches an output that is combinational or two cycles late.

// File: rtl/irq_hub_pkg.sv
// Shared types and register-window layout for the interrupt request hub.
package irq_hub_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } acc_size_e;

    localparam int REG_W    = 16;   // architectural register width
    localparam int LANES    = REG_W / 8;
    localparam int OFS_EN   = 0;    // enable register (and word-access base)
    localparam int OFS_FLAG = 2;    // request flag register
    localparam int OFS_MST  = 8;    // master enable
endpackage

// File: rtl/irq_hub_regif.sv
// Bus decode for the hub. It turns one access into per-register write
// controls and a read mux. It is purely combinational and holds no state.
// Assumes one access per cycle while bus_req is high, with data in the low
// lanes.
module irq_hub_regif
    import irq_hub_pkg::*;
#(
    parameter int NUM_SRC = 14,
    parameter int ADDR_W  = 4
) (
    input  logic               bus_req,
    input  logic               bus_we,
    input  logic [1:0]         bus_size,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    input  logic [NUM_SRC-1:0] en_q,
    input  logic [NUM_SRC-1:0] flag_q,
    input  logic               mst_q,
    output logic [LANES-1:0]   en_be,
    output logic [REG_W-1:0]   en_wval,
    output logic [NUM_SRC-1:0] clr_mask,
    output logic               mst_we,
    output logic               mst_wval,
    output logic [31:0]        bus_rdata
);
    localparam logic [ADDR_W-1:0] A_EN0 = ADDR_W'(OFS_EN);
    localparam logic [ADDR_W-1:0] A_EN1 = ADDR_W'(OFS_EN + 1);
    localparam logic [ADDR_W-1:0] A_FL0 = ADDR_W'(OFS_FLAG);
    localparam logic [ADDR_W-1:0] A_FL1 = ADDR_W'(OFS_FLAG + 1);
    localparam logic [ADDR_W-1:0] A_MST = ADDR_W'(OFS_MST);

    acc_size_e        sz;
    logic [REG_W-1:0] en16;
    logic [REG_W-1:0] fl16;
    logic [REG_W-1:0] clr_full;
    logic             unused_clr;

    assign sz       = acc_size_e'(bus_size);
    assign en16     = REG_W'(en_q);
    assign fl16     = REG_W'(flag_q);
    assign clr_mask = clr_full[NUM_SRC-1:0];
    assign unused_clr = ^clr_full;
    assign mst_wval = bus_wdata[0];

    // Decode writes into lane enables / acknowledge mask, and mux reads.
    always_comb begin
        en_be     = '0;
        en_wval   = '0;
        clr_full  = '0;
        mst_we    = 1'b0;
        bus_rdata = '0;
        if (bus_req && bus_we) begin
            case (sz)
                SZ_BYTE: begin
                    if (bus_addr == A_EN0) begin
                        en_be = 2'b01; en_wval = {8'h00, bus_wdata[7:0]};
                    end else if (bus_addr == A_EN1) begin
                        en_be = 2'b10; en_wval = {bus_wdata[7:0], 8'h00};
                    end else if (bus_addr == A_FL0) begin
                        clr_full = {8'h00, bus_wdata[7:0]};
                    end else if (bus_addr == A_FL1) begin
                        clr_full = {bus_wdata[7:0], 8'h00};
                    end else if (bus_addr == A_MST) begin
                        mst_we = 1'b1;
                    end
                end
                SZ_HALF: begin
                    if (bus_addr == A_EN0) begin
                        en_be = 2'b11; en_wval = bus_wdata[15:0];
                    end else if (bus_addr == A_FL0) begin
                        clr_full = bus_wdata[15:0];
                    end else if (bus_addr == A_MST) begin
                        mst_we = 1'b1;
                    end
                end
                SZ_WORD: begin
                    if (bus_addr == A_EN0) begin
                        en_be    = 2'b11;
                        en_wval  = bus_wdata[15:0];
                        clr_full = bus_wdata[31:16];
                    end else if (bus_addr == A_MST) begin
                        mst_we = 1'b1;
                    end
                end
                default: ;
            endcase
        end else if (bus_req) begin
            case (sz)
                SZ_BYTE: begin
                    if (bus_addr == A_EN0)      bus_rdata = {24'h0, en16[7:0]};
                    else if (bus_addr == A_EN1) bus_rdata = {24'h0, en16[15:8]};
                    else if (bus_addr == A_FL0) bus_rdata = {24'h0, fl16[7:0]};
                    else if (bus_addr == A_FL1) bus_rdata = {24'h0, fl16[15:8]};
                    else if (bus_addr == A_MST) bus_rdata = {31'h0, mst_q};
                end
                SZ_HALF: begin
                    if (bus_addr == A_EN0)      bus_rdata = {16'h0, en16};
                    else if (bus_addr == A_FL0) bus_rdata = {16'h0, fl16};
                    else if (bus_addr == A_MST) bus_rdata = {31'h0, mst_q};
                end
                SZ_WORD: begin
                    if (bus_addr == A_EN0)      bus_rdata = {fl16, en16};
                    else if (bus_addr == A_MST) bus_rdata = {31'h0, mst_q};
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/irq_hub_ctl.sv
// Enable register, written byte lane by byte lane, and the master bit.
// Assumes the decoder raises at most one write source per cycle.
module irq_hub_ctl
    import irq_hub_pkg::*;
#(
    parameter int NUM_SRC = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LANES-1:0]   en_be,
    input  logic [REG_W-1:0]   en_wval,
    input  logic               mst_we,
    input  logic               mst_wval,
    output logic [NUM_SRC-1:0] en_q,
    output logic               mst_q
);
    logic [REG_W-1:0] en_cur;
    logic [REG_W-1:0] en_nxt;
    logic             unused_en;

    assign en_cur    = REG_W'(en_q);
    assign unused_en = ^en_nxt;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign en_nxt[l*8 +: 8] = en_be[l] ? en_wval[l*8 +: 8] : en_cur[l*8 +: 8];
    end

    // Hold the enable bits and the master bit; clear both on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            mst_q <= 1'b0;
        end else begin
            en_q <= en_nxt[NUM_SRC-1:0];
            if (mst_we) mst_q <= mst_wval;
        end
    end
endmodule

// File: rtl/irq_hub_flags.sv
// Sticky request flags. Each flag sets on a rising edge of its event line
// and clears on an acknowledge bit; set wins over clear in the same cycle.
// Assumes the event lines are already synchronous to clk.
module irq_hub_flags #(
    parameter int NUM_SRC = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_in,
    input  logic [NUM_SRC-1:0] clr_mask,
    output logic [NUM_SRC-1:0] flag_q,
    output logic [NUM_SRC-1:0] evt_rise
);
    logic [NUM_SRC-1:0] evt_d;

    assign evt_rise = evt_in & ~evt_d;

    // Remember last cycle's event levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_d <= '0;
        else        evt_d <= evt_in;
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
        // One flag: set on edge, clear on acknowledge, set has priority.
        always_ff @(posedge clk) begin
            if (!rst_n)           flag_q[i] <= 1'b0;
            else if (evt_rise[i]) flag_q[i] <= 1'b1;
            else if (clr_mask[i]) flag_q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_hub_out.sv
// Registered interrupt output: master AND any enabled pending flag.
// Assumes the inputs are register outputs, so a one-cycle delay is expected.
module irq_hub_out #(
    parameter int NUM_SRC = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mst_q,
    input  logic [NUM_SRC-1:0] en_q,
    input  logic [NUM_SRC-1:0] flag_q,
    output logic               irq_out
);
    // Register the combined interrupt condition.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_out <= 1'b0;
        else        irq_out <= mst_q & (|(en_q & flag_q));
    end
endmodule

// File: rtl/irq_hub.sv
// Top of the interrupt request hub: bus decode, enable/master storage,
// sticky flags and the registered output. Assumes the caller has already
// decoded the 16-byte window.
module irq_hub
    import irq_hub_pkg::*;
#(
    parameter int NUM_SRC = 14,
    parameter int ADDR_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_req,
    input  logic               bus_we,
    input  logic [1:0]         bus_size,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_SRC-1:0] evt_in,
    output logic               irq_out
);
    logic [LANES-1:0]   en_be;
    logic [REG_W-1:0]   en_wval;
    logic [NUM_SRC-1:0] clr_mask;
    logic               mst_we;
    logic               mst_wval;
    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] flag_q;
    logic [NUM_SRC-1:0] evt_rise;
    logic               mst_q;

    irq_hub_regif #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regif (
        .bus_req(bus_req), .bus_we(bus_we), .bus_size(bus_size),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .en_q(en_q), .flag_q(flag_q), .mst_q(mst_q),
        .en_be(en_be), .en_wval(en_wval), .clr_mask(clr_mask),
        .mst_we(mst_we), .mst_wval(mst_wval), .bus_rdata(bus_rdata)
    );

    irq_hub_ctl #(.NUM_SRC(NUM_SRC)) u_ctl (
        .clk(clk), .rst_n(rst_n), .en_be(en_be), .en_wval(en_wval),
        .mst_we(mst_we), .mst_wval(mst_wval), .en_q(en_q), .mst_q(mst_q)
    );

    irq_hub_flags #(.NUM_SRC(NUM_SRC)) u_flags (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .clr_mask(clr_mask),
        .flag_q(flag_q), .evt_rise(evt_rise)
    );

    irq_hub_out #(.NUM_SRC(NUM_SRC)) u_out (
        .clk(clk), .rst_n(rst_n), .mst_q(mst_q), .en_q(en_q),
        .flag_q(flag_q), .irq_out(irq_out)
    );
endmodule

// File: rtl/irq_hub_chk.sv
// Property checker for irq_hub, attached through bind. It observes only.
module irq_hub_chk #(
    parameter int NUM_SRC = 14,
    parameter int ADDR_W  = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_req,
    input logic               bus_we,
    input logic [1:0]         bus_size,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [31:0]        bus_rdata,
    input logic [NUM_SRC-1:0] evt_in,
    input logic               irq_out,
    input logic [NUM_SRC-1:0] en_q,
    input logic [NUM_SRC-1:0] flag_q,
    input logic [NUM_SRC-1:0] evt_rise,
    input logic               mst_q
);
    logic unused_evt;
    assign unused_evt = ^evt_in;

    assert_reset_out_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !irq_out);

    assert_edge_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        |evt_rise |=> ((flag_q & $past(evt_rise)) == $past(evt_rise)));

    assert_no_silent_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(bus_req && bus_we)) |-> (($past(flag_q) & ~flag_q) == '0));

    assert_master_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && bus_addr == ADDR_W'(8)) |-> (bus_rdata[31:1] == 31'h0));

    assert_irq_timing_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq_out == $past(mst_q && ((en_q & flag_q) != '0))));

    assert_pad_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && bus_size == 2'd1 && bus_addr == ADDR_W'(2)) |-> (bus_rdata[15:14] == 2'b00));
endmodule

bind irq_hub irq_hub_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/irq_hub_tb.sv
module irq_hub_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [1:0]  bus_size = 2'd0;
    logic [3:0]  bus_addr = 4'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic [13:0] evt_in = 14'd0;
    logic        irq_out;

    int n_chk = 0, n_bad = 0;
    string cur_tag = "R1";

    logic [13:0] m_en = 0, m_fl = 0, m_evd = 0;
    logic        m_mst = 0, m_irq = 0;

    always #10 clk = ~clk;

    irq_hub u_dut (.clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .evt_in(evt_in), .irq_out(irq_out));

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected read data per the requirements (R6, R8, R10).
    function automatic logic [31:0] mread(logic [1:0] sz, logic [3:0] a);
        logic [15:0] e, f;
        e = {2'b00, m_en};
        f = {2'b00, m_fl};
        case (sz)
            2'd0: case (a)
                4'h0: return {24'h0, e[7:0]};
                4'h1: return {24'h0, e[15:8]};
                4'h2: return {24'h0, f[7:0]};
                4'h3: return {24'h0, f[15:8]};
                4'h8: return {31'h0, m_mst};
                default: return 32'h0;
            endcase
            2'd1: case (a)
                4'h0: return {16'h0, e};
                4'h2: return {16'h0, f};
                4'h8: return {31'h0, m_mst};
                default: return 32'h0;
            endcase
            2'd2: case (a)
                4'h0: return {f, e};
                4'h8: return {31'h0, m_mst};
                default: return 32'h0;
            endcase
            default: return 32'h0;
        endcase
    endfunction

    // One bus cycle: drive, check read data and irq_out, then advance the model.
    task automatic step(bit req, bit we, logic [1:0] sz, logic [3:0] a,
                        logic [31:0] wd, logic [13:0] ev);
        logic [15:0] e16, clr;
        logic nmst, nirq;
        @(negedge clk);
        bus_req = req; bus_we = we; bus_size = sz; bus_addr = a;
        bus_wdata = wd; evt_in = ev;
        #1;
        if (req && !we) chk(cur_tag, bus_rdata, mread(sz, a));
        else            chk("R6 idle rdata", bus_rdata, 32'h0);
        chk("R9 irq_out", {31'h0, irq_out}, {31'h0, m_irq});
        e16 = {2'b00, m_en}; clr = 16'h0; nmst = m_mst;
        if (req && we) begin
            case (sz)
                2'd0: case (a)
                    4'h0: e16[7:0]  = wd[7:0];
                    4'h1: e16[15:8] = wd[7:0];
                    4'h2: clr = {8'h0, wd[7:0]};
                    4'h3: clr = {wd[7:0], 8'h0};
                    4'h8: nmst = wd[0];
                    default: ;
                endcase
                2'd1: case (a)
                    4'h0: e16 = wd[15:0];
                    4'h2: clr = wd[15:0];
                    4'h8: nmst = wd[0];
                    default: ;
                endcase
                2'd2: case (a)
                    4'h0: begin e16 = wd[15:0]; clr = wd[31:16]; end
                    4'h8: nmst = wd[0];
                    default: ;
                endcase
                default: ;
            endcase
        end
        nirq = m_mst & (|(m_en & m_fl));
        @(posedge clk);
        m_fl  = (m_fl & ~clr[13:0]) | (ev & ~m_evd);
        m_en  = e16[13:0];
        m_mst = nmst;
        m_irq = nirq;
        m_evd = ev;
    endtask

    task automatic rd(logic [1:0] sz, logic [3:0] a, logic [13:0] ev);
        step(1'b1, 1'b0, sz, a, 32'h0, ev);
    endtask

    task automatic wr(logic [1:0] sz, logic [3:0] a, logic [31:0] wd, logic [13:0] ev);
        step(1'b1, 1'b1, sz, a, wd, ev);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5EED_1234);
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        cur_tag = "R1 reset";
        rd(2'd2, 4'h0, 14'h0);
        rd(2'd0, 4'h8, 14'h0);

        // R2: rising edges set flags; a held line does not set again
        cur_tag = "R2 edge set";
        step(1'b0, 1'b0, 2'd0, 4'h0, 32'h0, 14'h3FFF);
        rd(2'd1, 4'h2, 14'h3FFF);
        wr(2'd1, 4'h2, 32'h0000_0001, 14'h3FFF);
        rd(2'd1, 4'h2, 14'h3FFF);
        step(1'b0, 1'b0, 2'd0, 4'h0, 32'h0, 14'h0);

        // R4: byte acknowledge of the upper flag byte, zeros keep flags
        cur_tag = "R4 ack";
        wr(2'd0, 4'h3, 32'hFFFF_FF0F, 14'h0);
        rd(2'd1, 4'h2, 14'h0);
        wr(2'd0, 4'h2, 32'h0000_0080, 14'h0);
        rd(2'd0, 4'h2, 14'h0);

        // R5: word write loads enable and acknowledges through the upper half
        cur_tag = "R5 word write";
        wr(2'd2, 4'h0, 32'h0006_F234, 14'h0);
        rd(2'd2, 4'h0, 14'h0);

        // R7: halfword replaces, byte lanes replace only their half
        cur_tag = "R7 enable write";
        wr(2'd0, 4'h1, 32'h0000_00AB, 14'h0);
        rd(2'd0, 4'h1, 14'h0);
        rd(2'd0, 4'h0, 14'h0);
        wr(2'd1, 4'h0, 32'h0000_0021, 14'h0);
        rd(2'd1, 4'h0, 14'h0);

        // R8 and R9: master keeps bit 0 only; irq follows one cycle later
        cur_tag = "R8 master";
        wr(2'd1, 4'h8, 32'h0000_FFFE, 14'h0);
        rd(2'd2, 4'h8, 14'h0);
        wr(2'd2, 4'h8, 32'hFFFF_FFFF, 14'h0);
        rd(2'd0, 4'h8, 14'h0);
        cur_tag = "R9 irq";
        step(1'b0, 1'b0, 2'd0, 4'h0, 32'h0, 14'h0001);
        step(1'b0, 1'b0, 2'd0, 4'h0, 32'h0, 14'h0001);
        step(1'b0, 1'b0, 2'd0, 4'h0, 32'h0, 14'h0001);
        chk("R9 irq asserted", {31'h0, irq_out}, 32'h1);

        // R3: set wins over a same-cycle acknowledge
        cur_tag = "R3 set priority";
        step(1'b0, 1'b0, 2'd0, 4'h0, 32'h0, 14'h0);
        wr(2'd1, 4'h2, 32'h0000_FFFF, 14'h0020);
        rd(2'd1, 4'h2, 14'h0020);

        // R10: unmapped offsets and size code 3 read zero, writes ignored
        cur_tag = "R10 unmapped";
        wr(2'd2, 4'h4, 32'hFFFF_FFFF, 14'h0);
        wr(2'd1, 4'h6, 32'hFFFF_FFFF, 14'h0);
        wr(2'd1, 4'hA, 32'hFFFF_FFFF, 14'h0);
        wr(2'd0, 4'hC, 32'hFFFF_FFFF, 14'h0);
        wr(2'd3, 4'h0, 32'hFFFF_FFFF, 14'h0);
        wr(2'd2, 4'h2, 32'hFFFF_FFFF, 14'h0);
        rd(2'd2, 4'h4, 14'h0);
        rd(2'd1, 4'hA, 14'h0);
        rd(2'd3, 4'h0, 14'h0);
        rd(2'd2, 4'h0, 14'h0);
        rd(2'd0, 4'h8, 14'h0);

        // R6: random mix of accesses and sparse events against the model
        cur_tag = "R6 random";
        for (int k = 0; k < 600; k++) begin
            logic [3:0] addrs [11];
            logic [13:0] ev;
            addrs = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h6, 4'h8, 4'h9, 4'hA, 4'hC, 4'hE};
            ev = 14'($urandom & $urandom & $urandom);
            step(($urandom % 5) != 0, ($urandom % 3) == 0, 2'($urandom % 4),
                 addrs[$urandom % 11], $urandom, ev);
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule